// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Matcher

This block is a debug match unit for a simple in-order core. It has four address slots. Each slot compares its programmed address against either the instruction-fetch address or the data-access bus. A shared control word arms each slot and selects what the slot watches: execution, data writes, data reads and writes, or I/O accesses. The control word also sets the size of an aligned compare window for each slot. When an armed slot matches, the block records a sticky hit bit in a status word and pulses a trap request to the core.

Software reaches the slots, the control word and the status word through a simple registered read/write port. A general-detect option lets a debugger catch any later attempt to touch these registers. When that option is set, the access is refused, a status flag is raised and the trap fires. Two event inputs, one for single-step and one for task-switch, also leave sticky flags in the status word for the trap handler to read.

Top module: `dbg_match_unit`

## Requirements
- R1: After a synchronous reset, the following all read as zero: every slot address, the control word, the status word, `reg_rdata` and `trap_req`.
- R2: The port selects by `reg_addr`: 0 to 3 are the slot addresses, 4 is the control word, 5 is the status word, and 6 and 7 read as zero. A read returns its data on `reg_rdata` in the cycle after `reg_re`.
- R3: Slot i is armed when control bit 2i or control bit 2i+1 is set, or when both are set. A slot that is not armed never matches.
- R4: Each slot has a 2-bit condition at control bits 16+4i and 17+4i, and a 2-bit length at control bits 18+4i and 19+4i. With condition 00, the slot matches only when `ifetch_valid` is high and `ifetch_addr` equals the slot address exactly. The length field has no effect under condition 00.
- R5: Condition 01 matches only data writes (`dacc_write`=1) that are not I/O (`dacc_io`=0). Condition 11 matches non-I/O data reads and data writes.
- R6: Condition 10 matches only I/O accesses (`dacc_io`=1), and only while `dbg_ext_en` is high. While `dbg_ext_en` is low it never matches.
- R7: A data slot's window is the aligned block holding its address. Length 00 gives 1 byte, 01 gives 2 bytes, 11 gives 4 bytes and 10 gives 8 bytes. An access covers 2^`dacc_size` bytes, aligned to that size. A match occurs when the access and the window overlap.
- R8: Status bits 0 to 3 are hit flags, one per slot. Several may be set in the same cycle. Hardware only sets them. A software write to the status word clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Software cannot set a flag.
- R9: `trap_req` is high for the one cycle after a clock edge at which an armed slot matches or a general-detect refusal occurs. The matching status bits are readable from that cycle on.
- R10: Control bits 10, 12, 14 and 15 always read as zero. Status bits 4 to 12 and 16 to 31 always read as zero.
- R11: While control bit 13 is set, any register read or write is refused. A refused access leaves all registers unchanged except two: status bit 13 is set and control bit 13 is cleared. A refused read returns zero, and a refused access raises `trap_req`.
- R12: A high `step_evt` sets sticky status bit 14, and a high `tswitch_evt` sets sticky status bit 15. Software clears them as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ifetch_valid | input | 1 | Instruction fetch in this cycle |
| ifetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access in this cycle |
| dacc_write | input | 1 | Data access is a write |
| dacc_io | input | 1 | Data access targets I/O space |
| dacc_size | input | 2 | Access size as log2 of the byte count |
| dacc_addr | input | 32 | Data access address, aligned to its size |
| dbg_ext_en | input | 1 | Allows I/O-condition matching |
| step_evt | input | 1 | Single-step event |
| tswitch_evt | input | 1 | Task-switch event |
| trap_req | output | 1 | Registered one-cycle debug trap request |

## Verification
The bench probes each window size just inside and just outside its upper edge. A wrong mask would show up either as a trap on the byte past the window or as a missed trap on the last byte inside it. It also checks that an execution slot ignores a 4-byte length, and that a write-only slot ignores reads and I/O writes. The status word is cleared bit by bit to confirm the AND-style write: a design that stored the written value would show an extra bit set after the partial clear, and one that ignored writes would keep both bits. Finally, the bench arms general detect and tries to overwrite a slot address. It then reads the same address back to prove the write was refused and that the detect bit dropped, since a design that left detect on would return zero from every later read.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  localparam int NUM_SLOTS_D = 4;
  localparam int RA_W        = 3;
  localparam int RW_W        = 32;

  localparam logic [31:0] CTL_WMASK = 32'hFFFF_2BFF;
  localparam logic [31:0] ST_WMASK  = 32'h0000_E00F;
  localparam int GD_BIT    = 13;
  localparam int STEP_BIT  = 14;
  localparam int TSW_BIT   = 15;
  localparam int FIELD_LSB = 16;

  typedef enum logic [1:0] {
    COND_EXEC = 2'b00,
    COND_WR   = 2'b01,
    COND_IO   = 2'b10,
    COND_RW   = 2'b11
  } cond_e;

  function automatic logic [2:0] len_mask(input logic [1:0] len);
    case (len)
      2'b00:   return 3'b000;
      2'b01:   return 3'b001;
      2'b11:   return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [2:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'b000;
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/dbg_cmp_slot.sv
module dbg_cmp_slot
  import dbg_match_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic [1:0]    cond,
  input  logic [1:0]    len,
  input  logic [AW-1:0] bp_addr,
  input  logic          ifetch_valid,
  input  logic [AW-1:0] ifetch_addr,
  input  logic          dacc_valid,
  input  logic          dacc_write,
  input  logic          dacc_io,
  input  logic [1:0]    dacc_size,
  input  logic [AW-1:0] dacc_addr,
  input  logic          dbg_ext_en,
  output logic          hit
);
  localparam int HI_W = AW - 3;

  logic [AW-1:0] ign_mask;
  logic          data_ovl;
  logic          exec_eq;
  logic          cond_hit;

  always_comb begin
    ign_mask = {{HI_W{1'b0}}, (len_mask(len) | size_mask(dacc_size))};
    data_ovl = ((dacc_addr ^ bp_addr) & ~ign_mask) == '0;
    exec_eq  = ifetch_valid && (ifetch_addr == bp_addr);
    unique case (cond_e'(cond))
      COND_EXEC: cond_hit = exec_eq;
      COND_WR:   cond_hit = dacc_valid && dacc_write && !dacc_io && data_ovl;
      COND_IO:   cond_hit = dacc_valid && dacc_io && dbg_ext_en && data_ovl;
      default:   cond_hit = dacc_valid && !dacc_io && data_ovl;
    endcase
    hit = armed && cond_hit;
  end

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !hit); // R3
  AST_EXEC_EXACT: assert property (@(posedge clk) disable iff (rst)
    (hit && cond == 2'b00) |-> (ifetch_valid && ifetch_addr == bp_addr)); // R4
  AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
    (cond == 2'b10 && !dbg_ext_en) |-> !hit); // R6
  AST_WR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hit && cond == 2'b01) |-> (dacc_write && !dacc_io)); // R5
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_match_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_D,
  parameter int AW        = RW_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [RA_W-1:0]        reg_addr,
  input  logic [RW_W-1:0]        reg_wdata,
  input  logic [NUM_SLOTS-1:0]   hit_vec,
  input  logic                   step_evt,
  input  logic                   tswitch_evt,
  output logic [RW_W-1:0]        reg_rdata,
  output logic [NUM_SLOTS*AW-1:0] bp_flat,
  output logic [2*NUM_SLOTS-1:0] en_bits,
  output logic [4*NUM_SLOTS-1:0] field_bits,
  output logic                   gd_fire,
  output logic                   cause_seen
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [RA_W-1:0] CTL_IDX = RA_W'(NUM_SLOTS);
  localparam logic [RA_W-1:0] ST_IDX  = RA_W'(NUM_SLOTS + 1);

  logic [AW-1:0]   bp_q [NUM_SLOTS];
  logic [RW_W-1:0] ctl_q;
  logic [RW_W-1:0] st_q;
  logic [RW_W-1:0] st_set;
  logic [RW_W-1:0] rd_mux;
  logic            wr_ok;
  logic            rd_ok;

  assign gd_fire = ctl_q[GD_BIT] && (reg_we || reg_re);
  assign wr_ok   = reg_we && !ctl_q[GD_BIT];
  assign rd_ok   = reg_re && !ctl_q[GD_BIT];

  always_comb begin
    st_set = '0;
    st_set[NUM_SLOTS-1:0] = hit_vec;
    st_set[GD_BIT]   = gd_fire;
    st_set[STEP_BIT] = step_evt;
    st_set[TSW_BIT]  = tswitch_evt;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr < CTL_IDX)      rd_mux = RW_W'(bp_q[reg_addr[SW-1:0]]);
    else if (reg_addr == CTL_IDX) rd_mux = ctl_q;
    else if (reg_addr == ST_IDX)  rd_mux = st_q;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_bp
      always_ff @(posedge clk) begin
        if (rst) bp_q[gi] <= '0;
        else if (wr_ok && reg_addr == RA_W'(gi)) bp_q[gi] <= reg_wdata[AW-1:0];
      end
      assign bp_flat[gi*AW +: AW] = bp_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      st_q      <= '0;
      reg_rdata <= '0;
    end else begin
      if (gd_fire)                              ctl_q[GD_BIT] <= 1'b0;
      else if (wr_ok && reg_addr == CTL_IDX)    ctl_q <= reg_wdata & CTL_WMASK;
      if (wr_ok && reg_addr == ST_IDX) st_q <= ((st_q & reg_wdata) | st_set) & ST_WMASK;
      else                             st_q <= (st_q | st_set) & ST_WMASK;
      if (gd_fire)    reg_rdata <= '0;
      else if (rd_ok) reg_rdata <= rd_mux;
    end
  end

  assign en_bits    = ctl_q[2*NUM_SLOTS-1:0];
  assign field_bits = ctl_q[FIELD_LSB +: 4*NUM_SLOTS];
  assign cause_seen = st_q[GD_BIT] || (|st_q[NUM_SLOTS-1:0]);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_ok && reg_addr == ST_IDX) |-> (($past(st_q) & ~st_q) == '0)); // R8
  AST_GD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    gd_fire |=> (!ctl_q[GD_BIT] && st_q[GD_BIT])); // R11
  AST_GD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (gd_fire && reg_addr == CTL_IDX) |=> ((ctl_q & ~(RW_W'(1) << GD_BIT)) == $past(ctl_q & ~(RW_W'(1) << GD_BIT)))); // R11
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_D,
  parameter int AW        = RW_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [RW_W-1:0]     reg_wdata,
  output logic [RW_W-1:0]     reg_rdata,
  input  logic                ifetch_valid,
  input  logic [AW-1:0]       ifetch_addr,
  input  logic                dacc_valid,
  input  logic                dacc_write,
  input  logic                dacc_io,
  input  logic [1:0]          dacc_size,
  input  logic [AW-1:0]       dacc_addr,
  input  logic                dbg_ext_en,
  input  logic                step_evt,
  input  logic                tswitch_evt,
  output logic                trap_req
);
  logic [NUM_SLOTS*AW-1:0]  bp_flat;
  logic [2*NUM_SLOTS-1:0]   en_bits;
  logic [4*NUM_SLOTS-1:0]   field_bits;
  logic [NUM_SLOTS-1:0]     hit_vec;
  logic                     gd_fire;
  logic                     cause_seen;

  dbg_regfile #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hit_vec(hit_vec),
    .step_evt(step_evt), .tswitch_evt(tswitch_evt), .reg_rdata(reg_rdata),
    .bp_flat(bp_flat), .en_bits(en_bits), .field_bits(field_bits),
    .gd_fire(gd_fire), .cause_seen(cause_seen)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      dbg_cmp_slot #(.AW(AW)) slot_i (
        .clk(clk), .rst(rst),
        .armed(|en_bits[2*gi +: 2]),
        .cond(field_bits[4*gi +: 2]),
        .len(field_bits[4*gi+2 +: 2]),
        .bp_addr(bp_flat[gi*AW +: AW]),
        .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dacc_valid(dacc_valid), .dacc_write(dacc_write), .dacc_io(dacc_io),
        .dacc_size(dacc_size), .dacc_addr(dacc_addr),
        .dbg_ext_en(dbg_ext_en), .hit(hit_vec[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= (|hit_vec) || gd_fire;
  end

  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> cause_seen); // R9
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(reg_re && !reg_we && reg_addr == RA_W'(NUM_SLOTS) && !gd_fire) |->
      ((reg_rdata & ~CTL_WMASK) == '0)); // R10
endmodule

// File: tb/dbg_match_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_match_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 0, reg_re = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ifetch_valid = 0;
  logic [31:0] ifetch_addr = 0;
  logic        dacc_valid = 0, dacc_write = 0, dacc_io = 0;
  logic [1:0]  dacc_size = 0;
  logic [31:0] dacc_addr = 0;
  logic        dbg_ext_en = 0, step_evt = 0, tswitch_evt = 0;
  logic        trap_req;

  int n_chk = 0, n_fail = 0;
  logic last_trap;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_match_unit dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ifetch_valid(ifetch_valid),
    .ifetch_addr(ifetch_addr), .dacc_valid(dacc_valid), .dacc_write(dacc_write),
    .dacc_io(dacc_io), .dacc_size(dacc_size), .dacc_addr(dacc_addr),
    .dbg_ext_en(dbg_ext_en), .step_evt(step_evt), .tswitch_evt(tswitch_evt),
    .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; last_trap = trap_req;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata; last_trap = trap_req;
  endtask

  task automatic data(input logic [31:0] a, input logic [1:0] sz,
                      input logic w, input logic io, output logic t);
    @(negedge clk); dacc_valid = 1; dacc_addr = a; dacc_size = sz; dacc_write = w; dacc_io = io;
    @(negedge clk); dacc_valid = 0; t = trap_req;
  endtask

  task automatic fetch(input logic [31:0] a, output logic t);
    @(negedge clk); ifetch_valid = 1; ifetch_addr = a;
    @(negedge clk); ifetch_valid = 0; t = trap_req;
  endtask

  function automatic logic [31:0] ctlv(input int s, input logic [1:0] en,
                                       input logic [1:0] cond, input logic [1:0] len);
    return (32'(en) << (2*s)) | (32'(cond) << (16+4*s)) | (32'(len) << (18+4*s));
  endfunction

  task automatic clear_all();
    wr(3'd4, 32'h0); wr(3'd5, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 trap after reset", 32'(trap_req), 0);
    rd(3'd0, d); chk("R1 slot0 addr", d, 0);
    rd(3'd4, d); chk("R1 control", d, 0);
    rd(3'd5, d); chk("R1 status", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(3'd0, 32'hA0); wr(3'd1, 32'hA1); wr(3'd2, 32'hA2); wr(3'd3, 32'hA3);
    rd(3'd2, d); chk("R2 slot2 readback", d, 32'hA2);
    rd(3'd3, d); chk("R2 slot3 readback", d, 32'hA3);
    rd(3'd6, d); chk("R2 addr6 zero", d, 0);
  endtask

  task automatic t_arm();
    logic t;
    wr(3'd0, 32'h700);
    wr(3'd4, ctlv(0, 2'b00, 2'b11, 2'b00));
    data(32'h700, 2'd0, 1, 0, t); chk("R3 disarmed no trap", 32'(t), 0);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b00));
    data(32'h700, 2'd0, 0, 0, t); chk("R3 local enable trap", 32'(t), 1);
    wr(3'd4, ctlv(0, 2'b10, 2'b11, 2'b00));
    data(32'h700, 2'd0, 1, 0, t); chk("R3 global enable trap", 32'(t), 1);
    clear_all();
  endtask

  task automatic t_exec();
    logic t; logic [31:0] d;
    wr(3'd2, 32'h400);
    wr(3'd4, ctlv(2, 2'b01, 2'b00, 2'b11));
    fetch(32'h400, t); chk("R4 exec hit", 32'(t), 1);
    rd(3'd5, d); chk("R4 status bit2", d, 32'h4);
    wr(3'd5, 32'h0);
    fetch(32'h401, t); chk("R4 length ignored", 32'(t), 0);
    data(32'h400, 2'd0, 1, 0, t); chk("R4 data ignored", 32'(t), 0);
    clear_all();
  endtask

  task automatic t_cond();
    logic t;
    wr(3'd3, 32'h500);
    wr(3'd4, ctlv(3, 2'b10, 2'b01, 2'b00));
    data(32'h500, 2'd0, 1, 0, t); chk("R5 write watch hit", 32'(t), 1);
    data(32'h500, 2'd0, 0, 0, t); chk("R5 read ignored", 32'(t), 0);
    data(32'h500, 2'd0, 1, 1, t); chk("R5 io write ignored", 32'(t), 0);
    wr(3'd4, ctlv(3, 2'b10, 2'b11, 2'b00));
    data(32'h500, 2'd0, 0, 0, t); chk("R5 rw read hit", 32'(t), 1);
    clear_all();
  endtask

  task automatic t_io();
    logic t;
    wr(3'd1, 32'h60);
    wr(3'd4, ctlv(1, 2'b01, 2'b10, 2'b00));
    dbg_ext_en = 0;
    data(32'h60, 2'd0, 1, 1, t); chk("R6 io gated off", 32'(t), 0);
    dbg_ext_en = 1;
    data(32'h60, 2'd0, 0, 1, t); chk("R6 io enabled hit", 32'(t), 1);
    data(32'h60, 2'd0, 1, 0, t); chk("R6 memory ignored", 32'(t), 0);
    dbg_ext_en = 0;
    clear_all();
  endtask

  task automatic t_len();
    logic t;
    wr(3'd0, 32'h100);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b11));
    data(32'h103, 2'd0, 0, 0, t); chk("R7 4B last byte", 32'(t), 1);
    data(32'h104, 2'd0, 0, 0, t); chk("R7 4B past end", 32'(t), 0);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b10));
    data(32'h107, 2'd0, 0, 0, t); chk("R7 8B last byte", 32'(t), 1);
    data(32'h108, 2'd0, 0, 0, t); chk("R7 8B past end", 32'(t), 0);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b01));
    data(32'h101, 2'd0, 0, 0, t); chk("R7 2B upper byte", 32'(t), 1);
    data(32'h102, 2'd0, 0, 0, t); chk("R7 2B past end", 32'(t), 0);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b00));
    data(32'h101, 2'd0, 0, 0, t); chk("R7 1B neighbour", 32'(t), 0);
    wr(3'd0, 32'h104);
    data(32'h100, 2'd3, 0, 0, t); chk("R7 wide access overlap", 32'(t), 1);
    clear_all();
  endtask

  task automatic t_sticky();
    logic t; logic [31:0] d;
    wr(3'd0, 32'h200); wr(3'd1, 32'h200);
    wr(3'd4, ctlv(0, 2'b01, 2'b11, 2'b00) | ctlv(1, 2'b10, 2'b11, 2'b00));
    data(32'h200, 2'd0, 1, 0, t); chk("R9 trap one cycle after hit", 32'(t), 1);
    @(negedge clk); chk("R9 trap is a pulse", 32'(trap_req), 0);
    rd(3'd5, d); chk("R8 two hits same cycle", d, 32'h3);
    wr(3'd5, 32'hFFFF_FFFE);
    rd(3'd5, d); chk("R8 partial clear", d, 32'h2);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R8 full clear", d, 32'h0);
    clear_all();
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(3'd4, 32'hFFFF_DFFF);
    rd(3'd4, d); chk("R10 control reserved bits", d, 32'hFFFF_0BFF);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R10 status not settable", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    @(negedge clk); step_evt = 1;
    @(negedge clk); step_evt = 0; tswitch_evt = 1;
    @(negedge clk); tswitch_evt = 0;
    rd(3'd5, d); chk("R12 step and switch flags", d, 32'h0000_C000);
    wr(3'd5, 32'h0000_8000);
    rd(3'd5, d); chk("R12 step flag cleared", d, 32'h0000_8000);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_gd();
    logic [31:0] d;
    wr(3'd0, 32'h11);
    wr(3'd4, 32'h0000_2000);
    wr(3'd0, 32'h22); chk("R11 refused write traps", 32'(last_trap), 1);
    rd(3'd5, d); chk("R11 detect flag set", d, 32'h0000_2000);
    rd(3'd4, d); chk("R11 detect enable cleared", d, 32'h0);
    rd(3'd0, d); chk("R11 slot unchanged", d, 32'h11);
    wr(3'd4, 32'h0000_2000);
    rd(3'd0, d); chk("R11 refused read zero", d, 32'h0);
    wr(3'd5, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    t_reset(); t_map(); t_arm(); t_exec(); t_cond(); t_io();
    t_len(); t_sticky(); t_rsvd(); t_events(); t_gd();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule